// File: doc/BRIEF.md
# Dual-Tone Scale and Sum Stage

This block sits after two sine generators in each output lane of a waveform synthesiser. Every clock it receives, for each parallel lane, one full-scale signed sample of tone A and one of tone B. It weights each sample by its own signed fixed-point gain, adds the two weighted samples, and presents one combined sample per lane. The lanes share one pair of gains and one set of controls, so the lanes of a multi-sample-per-clock converter path stay consistent.

Each gain is a 16-bit signed value with one sign bit, one integer bit and fourteen fraction bits, so 0x4000 stands for a gain of exactly one. A weighted sample is the full product shifted right by fourteen with the low bits dropped, which rounds toward minus infinity. The sum is not clamped: if the two gains are large enough to push the result outside the sample range, it wraps. The combined word can be emitted as two's complement or as offset binary. A mute control forces the output to zero. The stage has a fixed two-cycle pipeline delay, and a valid strobe travels with the data.

Top module: `dual_tone_mix`

## Requirements
- R1: With gain A = 0x4000 (unity in the 1.1.14 format), gain B = 0, mute low and two's complement output selected, each lane's output equals its tone A input.
- R2: A weighted sample is floor(tone x gain / 2^14): tone 3 with gain 0x2000 gives 1, tone -3 with gain 0x2000 gives -2.
- R3: The output of a lane is the weighted tone A sample plus the weighted tone B sample of that lane, kept to DW bits.
- R4: Over-range wraps and is not saturated: with DW = 16, both tones at 0x7FFF and both gains at 0x4000 give 0xFFFE.
- R5: A negative gain negates: gain 0xC000 (minus one) on tone -32768 gives +32768, which wraps to 0x8000 in 16 bits.
- R6: With the format select at 1, the output is offset binary: the two's complement result with its most significant bit inverted (a zero result reads 0x8000 for DW = 16); with the select at 0 the two's complement word is output.
- R7: With mute high, the lane outputs are all-zero words whatever the tones, gains or format select.
- R8: The output sample and out_vld appear exactly two clock edges after the inputs are sampled; out_vld is in_vld delayed by two cycles.
- R9: Lane i occupies bits [i*DW +: DW] of the tone and output buses, and each lane is computed from its own tones only.
- R10: While reset is high, out_vld and every output bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_offset | input | 1 | 0 selects two's complement output, 1 selects offset binary |
| mute | input | 1 | Forces the output samples to zero |
| in_vld | input | 1 | Marks the current inputs as a new sample |
| gain_a | input | 16 | Tone A gain, signed 1.1.14 |
| gain_b | input | 16 | Tone B gain, signed 1.1.14 |
| tone_a | input | LANES*DW | Tone A samples, lane i in bits [i*DW +: DW] |
| tone_b | input | LANES*DW | Tone B samples, lane i in bits [i*DW +: DW] |
| out_vld | output | 1 | in_vld delayed by two cycles |
| out_data | output | LANES*DW | Combined samples, lane i in bits [i*DW +: DW] |

## Verification
A wrong alignment of the product slice shows as outputs off by a power of two for the unity and half-gain vectors, two cycles after the inputs. A broken control pipeline shows as the mute or format setting being applied one cycle early or late, so the sample two edges after a change carries the wrong format, and as out_vld not lining up with the data. Clamping instead of wrapping, or a truncation that rounds toward zero, shows only on the over-range, negated-minimum and negative-odd vectors, again in the second cycle.

// File: rtl/tsum_pkg.sv
package tsum_pkg;

    // Gain word layout: sign, one integer bit, fraction bits
    localparam int GAIN_W = 16;
    localparam int FRAC_W = 14;

    typedef enum logic {
        FMT_TWOS   = 1'b0,
        FMT_OFFSET = 1'b1
    } out_fmt_e;

    // Control word that travels alongside the samples
    typedef struct packed {
        logic     vld;
        logic     mute;
        out_fmt_e fmt;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{vld: 1'b0, mute: 1'b0, fmt: FMT_TWOS};

    function automatic ctl_t pack_ctl(input logic vld, input logic mute, input logic fmt);
        ctl_t c;
        c.vld  = vld;
        c.mute = mute;
        c.fmt  = fmt ? FMT_OFFSET : FMT_TWOS;
        return c;
    endfunction

endpackage

// File: rtl/tsum_ctl_pipe.sv
module tsum_ctl_pipe
    import tsum_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  ctl_t ctl_in,
    output ctl_t ctl_s1,
    output ctl_t ctl_out
);
    ctl_t stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= CTL_IDLE;
                    else     stage_q[s] <= ctl_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= CTL_IDLE;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign ctl_s1  = stage_q[0];
    assign ctl_out = stage_q[STAGES-1];
endmodule

// File: rtl/tsum_mul_lane.sv
module tsum_mul_lane
    import tsum_pkg::*;
#(
    parameter int DW = 16,
    localparam int MW = DW + GAIN_W,
    localparam int PW = DW + 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [DW-1:0] tone_a,
    input  logic signed [DW-1:0] tone_b,
    input  logic signed [GAIN_W-1:0] gain_a,
    input  logic signed [GAIN_W-1:0] gain_b,
    output logic signed [PW-1:0] prod_a,
    output logic signed [PW-1:0] prod_b
);
    logic signed [MW-1:0] full_a;
    logic signed [MW-1:0] full_b;

    assign full_a = MW'(tone_a) * MW'(gain_a);
    assign full_b = MW'(tone_b) * MW'(gain_b);

    // The dropped fraction bits are discarded on purpose (floor truncation)
    logic unused_frac;
    assign unused_frac = ^{full_a[FRAC_W-1:0], full_b[FRAC_W-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_a <= '0;
            prod_b <= '0;
        end else begin
            prod_a <= full_a[FRAC_W +: PW];
            prod_b <= full_b[FRAC_W +: PW];
        end
    end
endmodule

// File: rtl/tsum_add_lane.sv
module tsum_add_lane
    import tsum_pkg::*;
#(
    parameter int DW = 16,
    localparam int PW = DW + 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [PW-1:0] prod_a,
    input  logic signed [PW-1:0] prod_b,
    input  ctl_t                 ctl,
    output logic [DW-1:0]        sample
);
    logic signed [PW-1:0] total;
    logic [DW-1:0]        wrapped;
    logic [DW-1:0]        shaped;

    assign total   = prod_a + prod_b;
    assign wrapped = total[DW-1:0];

    // Bits above DW are dropped: over-range wraps
    logic unused_top;
    assign unused_top = ^total[PW-1:DW];

    always_comb begin
        if (ctl.mute)
            shaped = '0;
        else if (ctl.fmt == FMT_OFFSET)
            shaped = {~wrapped[DW-1], wrapped[DW-2:0]};
        else
            shaped = wrapped;
    end

    always_ff @(posedge clk) begin
        if (rst) sample <= '0;
        else     sample <= shaped;
    end
endmodule

// File: rtl/dual_tone_mix.sv
module dual_tone_mix
    import tsum_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DW    = 16,
    localparam int BUS_W = LANES * DW,
    localparam int PW    = DW + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fmt_offset,
    input  logic              mute,
    input  logic              in_vld,
    input  logic [GAIN_W-1:0] gain_a,
    input  logic [GAIN_W-1:0] gain_b,
    input  logic [BUS_W-1:0]  tone_a,
    input  logic [BUS_W-1:0]  tone_b,
    output logic              out_vld,
    output logic [BUS_W-1:0]  out_data
);
    ctl_t ctl_in;
    ctl_t ctl_s1;
    ctl_t ctl_s2;

    assign ctl_in = pack_ctl(in_vld, mute, fmt_offset);

    tsum_ctl_pipe #(.STAGES(2)) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .ctl_in  (ctl_in),
        .ctl_s1  (ctl_s1),
        .ctl_out (ctl_s2)
    );

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            logic signed [PW-1:0] pa;
            logic signed [PW-1:0] pb;

            tsum_mul_lane #(.DW(DW)) u_mul (
                .clk    (clk),
                .rst    (rst),
                .tone_a (tone_a[i*DW +: DW]),
                .tone_b (tone_b[i*DW +: DW]),
                .gain_a (gain_a),
                .gain_b (gain_b),
                .prod_a (pa),
                .prod_b (pb)
            );

            tsum_add_lane #(.DW(DW)) u_add (
                .clk    (clk),
                .rst    (rst),
                .prod_a (pa),
                .prod_b (pb),
                .ctl    (ctl_s1),
                .sample (out_data[i*DW +: DW])
            );
        end
    endgenerate

    assign out_vld = ctl_s2.vld;
endmodule

// File: rtl/dual_tone_mix_chk.sv
module dual_tone_mix_chk #(
    parameter int LANES = 4,
    parameter int DW    = 16,
    localparam int BUS_W = LANES * DW
) (
    input logic              clk,
    input logic              rst,
    input logic              fmt_offset,
    input logic              mute,
    input logic              in_vld,
    input logic [15:0]       gain_a,
    input logic [15:0]       gain_b,
    input logic [BUS_W-1:0]  tone_a,
    input logic [BUS_W-1:0]  out_data,
    input logic              out_vld
);
    localparam logic [BUS_W-1:0] OFS_ZERO = {LANES{{1'b1, {(DW-1){1'b0}}}}};

    logic [1:0] warm_cnt;
    logic       warm;

    always_ff @(posedge clk) begin
        if (rst)                 warm_cnt <= 2'd0;
        else if (warm_cnt != 2'd2) warm_cnt <= warm_cnt + 2'd1;
    end
    assign warm = (warm_cnt == 2'd2);

    // R8
    vld_delay_chk: assert property (@(posedge clk) disable iff (rst)
        warm |-> (out_vld == $past(in_vld, 2)));

    // R7
    mute_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(mute, 2)) |-> (out_data == '0));

    // R1
    unity_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(gain_a == 16'h4000 && gain_b == 16'h0000 && !mute && !fmt_offset, 2))
        |-> (out_data == $past(tone_a, 2)));

    // R6
    offset_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(gain_a == 16'h0000 && gain_b == 16'h0000 && !mute && fmt_offset, 2))
        |-> (out_data == OFS_ZERO));
endmodule

bind dual_tone_mix dual_tone_mix_chk #(.LANES(LANES), .DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fmt_offset (fmt_offset),
    .mute       (mute),
    .in_vld     (in_vld),
    .gain_a     (gain_a),
    .gain_b     (gain_b),
    .tone_a     (tone_a),
    .out_data   (out_data),
    .out_vld    (out_vld)
);

// File: tb/dual_tone_mix_test.sv
module dual_tone_mix_test;
    localparam int LANES = 4;
    localparam int DW    = 16;
    localparam int BUS_W = LANES * DW;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             fmt_offset = 1'b0;
    logic             mute = 1'b0;
    logic             in_vld = 1'b0;
    logic [15:0]      gain_a = '0;
    logic [15:0]      gain_b = '0;
    logic [BUS_W-1:0] tone_a = '0;
    logic [BUS_W-1:0] tone_b = '0;
    logic             out_vld;
    logic [BUS_W-1:0] out_data;

    int total = 0;
    int bad   = 0;

    dual_tone_mix #(.LANES(LANES), .DW(DW)) uut (
        .clk(clk), .rst(rst), .fmt_offset(fmt_offset), .mute(mute),
        .in_vld(in_vld), .gain_a(gain_a), .gain_b(gain_b),
        .tone_a(tone_a), .tone_b(tone_b), .out_vld(out_vld), .out_data(out_data)
    );

    always #4 clk = ~clk;

    function automatic logic [DW-1:0] model(input logic [DW-1:0] ta, input logic [DW-1:0] tb,
                                            input logic [15:0] ga, input logic [15:0] gb,
                                            input logic fmt, input logic mu);
        longint pa, pb, s;
        logic [DW-1:0] r;
        pa = (longint'($signed(ta)) * longint'($signed(ga))) >>> 14;
        pb = (longint'($signed(tb)) * longint'($signed(gb))) >>> 14;
        s  = pa + pb;
        r  = s[DW-1:0];
        if (fmt) r[DW-1] = ~r[DW-1];
        if (mu)  r = '0;
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    // Drive one sample at a falling edge and check it two rising edges later
    task automatic apply(input string req, input logic [BUS_W-1:0] ta, input logic [BUS_W-1:0] tb,
                         input logic [15:0] ga, input logic [15:0] gb,
                         input logic fmt, input logic mu);
        logic [DW-1:0] e;
        @(negedge clk);
        tone_a = ta; tone_b = tb; gain_a = ga; gain_b = gb;
        fmt_offset = fmt; mute = mu; in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
        check(out_vld == 1'b0, {req, " R8 vld early"}, 64'(out_vld), 64'd0);
        @(negedge clk);
        check(out_vld == 1'b1, {req, " R8 vld"}, 64'(out_vld), 64'd1);
        for (int i = 0; i < LANES; i++) begin
            e = model(ta[i*DW +: DW], tb[i*DW +: DW], ga, gb, fmt, mu);
            check(out_data[i*DW +: DW] == e, req, 64'(out_data[i*DW +: DW]), 64'(e));
        end
    endtask

    task automatic t_reset();
        // R10
        @(negedge clk);
        check(out_vld == 1'b0 && out_data == '0, "R10 reset", {out_data[62:0], out_vld}, 64'd0);
    endtask

    task automatic t_unity();
        apply("R1 unity", {16'h7FFF, 16'h8000, 16'h1234, 16'hFFFF}, {4{16'h5555}}, 16'h4000, 16'h0000, 1'b0, 1'b0);
    endtask

    task automatic t_floor();
        apply("R2 floor", {16'h0003, 16'hFFFD, 16'h0001, 16'hFFFF}, '0, 16'h2000, 16'h0000, 1'b0, 1'b0);
    endtask

    task automatic t_sum();
        apply("R3 sum", {16'h1000, 16'hF000, 16'h0100, 16'h2222}, {16'h0800, 16'h0400, 16'hFF00, 16'h1111}, 16'h2000, 16'h4000, 1'b0, 1'b0);
    endtask

    task automatic t_wrap();
        apply("R4 wrap", {4{16'h7FFF}}, {4{16'h7FFF}}, 16'h4000, 16'h4000, 1'b0, 1'b0);
    endtask

    task automatic t_negate();
        apply("R5 negate", {16'h8000, 16'h0001, 16'h7FFF, 16'h0000}, '0, 16'hC000, 16'h0000, 1'b0, 1'b0);
    endtask

    task automatic t_offset();
        apply("R6 offset", {16'h0000, 16'h7FFF, 16'h8000, 16'h0010}, '0, 16'h4000, 16'h0000, 1'b1, 1'b0);
        apply("R6 offset zero", {4{16'h1234}}, {4{16'h4321}}, 16'h0000, 16'h0000, 1'b1, 1'b0);
    endtask

    task automatic t_mute();
        apply("R7 mute", {4{16'h3333}}, {4{16'h1111}}, 16'h4000, 16'h4000, 1'b0, 1'b1);
        apply("R7 mute offset", {4{16'h3333}}, {4{16'h1111}}, 16'h4000, 16'h2000, 1'b1, 1'b1);
    endtask

    task automatic t_lanes();
        apply("R9 lanes", {16'h0004, 16'h0003, 16'h0002, 16'h0001}, {16'h0040, 16'h0030, 16'h0020, 16'h0010}, 16'h4000, 16'h4000, 1'b0, 1'b0);
    endtask

    task automatic t_back_to_back();
        // R8: consecutive samples each appear two edges after their inputs
        @(negedge clk);
        tone_a = {4{16'h0100}}; tone_b = '0; gain_a = 16'h4000; gain_b = 16'h0000;
        fmt_offset = 1'b0; mute = 1'b0; in_vld = 1'b1;
        @(negedge clk);
        tone_a = {4{16'h0200}};
        @(negedge clk);
        in_vld = 1'b0; tone_a = {4{16'h0300}};
        check(out_vld && out_data == {4{16'h0100}}, "R8 stream first", 64'(out_data[15:0]), 64'h0100);
        @(negedge clk);
        check(out_vld && out_data == {4{16'h0200}}, "R8 stream second", 64'(out_data[15:0]), 64'h0200);
        @(negedge clk);
        check(!out_vld, "R8 stream end", 64'(out_vld), 64'd0);
    endtask

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL R8 watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        t_unity();
        t_floor();
        t_sum();
        t_wrap();
        t_negate();
        t_offset();
        t_mute();
        t_lanes();
        t_back_to_back();
        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule